// File: doc/BRIEF.md
# Burst Column Sequence Generator

This block turns one burst command into the ordered list of column addresses that the burst visits. A command carries a starting column, a burst-length code and an ordering bit. The block then emits two column addresses per clock (an even beat and an odd beat) until the burst is complete. The final pair is marked, and a valid flag tags every cycle that carries a pair.

A burst stays inside the aligned block of columns that its length selects. Sequential ordering counts upward and wraps inside that block. Interleaved ordering XORs the beat number into the starting offset. The column bits above the block never change during a burst. A full-page mode walks every column of the row upward from an even start and keeps running until it is cut.

Any running burst is cut short by a stop pulse or by a new command. An illegal command raises a one-cycle error flag and produces no addresses. The block does not touch memory, strobes or read latency. It only supplies the column order.

Top module: `burst_col_seq`

## Requirements
- R1: Out of reset, pairValid, pairLast and cfgErr are all low.
- R2: A legal startPulse sampled at a clock edge makes the first pair valid in the next cycle, and later pairs follow on consecutive cycles. lenCode 3'b001 gives 2 beats (1 cycle), 3'b010 gives 4 beats (2 cycles) and 3'b011 gives 8 beats (4 cycles). pairLast is high only on the final pair, and pairValid is low in the cycle after it.
- R3: With typeIlv = 0 (sequential), beat i has the in-block offset (start offset + i) mod length. For example, start 5 with length 8 gives 5,6,7,0,1,2,3,4.
- R4: With typeIlv = 1 (interleaved), beat i has the in-block offset (start offset XOR i). For example, start 5 with length 8 gives 5,4,7,6,1,0,3,2.
- R5: The column bits above the aligned block are those of startCol for every beat. For example, start 8'h2D with length 4 stays inside 8'h2C..8'h2F.
- R6: lenCode 3'b111 with typeIlv = 0 and an even startCol is full page. Beat i is (startCol + i) mod 256, pairLast never rises, and the burst runs until it is cut.
- R7: A stopPulse sampled at an edge without startPulse makes pairValid low from the next cycle onward. No further beats of that burst appear.
- R8: A legal startPulse during a running burst replaces that burst. The next cycle carries the first pair of the new burst.
- R9: If startPulse and stopPulse are sampled at the same edge, the start wins and the new burst begins as in R2.
- R10: A reserved lenCode (3'b000, 3'b100, 3'b101 or 3'b110), full page with typeIlv = 1, or full page with an odd startCol sets cfgErr for exactly the next cycle. No pair is produced, and any running burst ends.
- R11: The column pair presented in any valid cycle differs in bit 0. The even beat is on colEven and the odd beat is on colOdd.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| startPulse | input | 1 | Burst command strobe |
| stopPulse | input | 1 | Burst cut strobe |
| lenCode | input | 3 | Burst-length code |
| typeIlv | input | 1 | 0 sequential, 1 interleaved |
| startCol | input | COL_W (8) | Starting column |
| colEven | output | COL_W (8) | Column of beat 2k |
| colOdd | output | COL_W (8) | Column of beat 2k+1 |
| pairValid | output | 1 | Current pair is part of a burst |
| pairLast | output | 1 | Current pair ends the burst |
| cfgErr | output | 1 | Previous command was illegal |

## Verification
Two events can fall on the same edge here: a burst reaching its end or being cut, and a new command being accepted. The bench raises startPulse together with stopPulse in the middle of a running burst. It also issues a new command exactly on the cycle that shows a burst's final pair. In both cases the cycle after must show the new burst's first pair, with the valid flag unbroken. A bad command issued mid-burst is checked to end the old burst and to flag the error alone.

// File: rtl/burst_col_pkg.sv
package burst_col_pkg;
  // strobes from control to the address datapath
  typedef struct packed {
    logic load;   // capture a new command, restart beat counting
    logic step;   // advance to the next beat pair
  } seqStrobe_t;

  localparam logic [2:0] LEN_TWO   = 3'b001;
  localparam logic [2:0] LEN_FOUR  = 3'b010;
  localparam logic [2:0] LEN_EIGHT = 3'b011;
  localparam logic [2:0] LEN_PAGE  = 3'b111;
endpackage

// File: rtl/burst_ctrl.sv
module burst_ctrl
  import burst_col_pkg::*;
#(
  parameter int COL_W = 8
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       startPulse,
  input  logic       stopPulse,
  input  logic [2:0] lenCode,
  input  logic       typeIlv,
  input  logic       startLsb,
  output seqStrobe_t strb,
  output logic       busy,
  output logic       lastPair,
  output logic       cfgErr
);
  localparam int PAIR_W = COL_W - 1;

  logic              cmdOk, isPage;
  logic [PAIR_W-1:0] lastIdx, pairsLeft;
  logic              pageRun;

  always_comb begin
    isPage  = 1'b0;
    cmdOk   = 1'b1;
    lastIdx = '0;
    case (lenCode)
      LEN_TWO:   lastIdx = PAIR_W'(0);
      LEN_FOUR:  lastIdx = PAIR_W'(1);
      LEN_EIGHT: lastIdx = PAIR_W'(3);
      LEN_PAGE: begin
        isPage = 1'b1;
        cmdOk  = !typeIlv && !startLsb;
      end
      default:   cmdOk = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy      <= 1'b0;
      pairsLeft <= '0;
      pageRun   <= 1'b0;
      cfgErr    <= 1'b0;
    end else begin
      cfgErr <= startPulse && !cmdOk;
      if (startPulse) begin
        busy      <= cmdOk;
        pairsLeft <= lastIdx;
        pageRun   <= isPage;
      end else if (stopPulse) begin
        busy <= 1'b0;
      end else if (busy) begin
        if (!pageRun && pairsLeft == '0) busy <= 1'b0;
        else pairsLeft <= pairsLeft - 1'b1;
      end
    end
  end

  assign lastPair  = busy && !pageRun && pairsLeft == '0;
  assign strb.load = startPulse && cmdOk;
  assign strb.step = busy && !startPulse && !stopPulse;
endmodule

// File: rtl/burst_addr.sv
module burst_addr
  import burst_col_pkg::*;
#(
  parameter int COL_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  seqStrobe_t       strb,
  input  logic [2:0]       lenCode,
  input  logic             typeIlv,
  input  logic [COL_W-1:0] startCol,
  output logic [COL_W-1:0] colEven,
  output logic [COL_W-1:0] colOdd
);
  localparam int PAIR_W = COL_W - 1;
  localparam int LANES  = 2;

  logic [COL_W-1:0]  maskSel, baseReg, maskReg, offs;
  logic              ilvReg;
  logic [PAIR_W-1:0] pairIdx;
  logic [LANES-1:0][COL_W-1:0] laneCol;

  always_comb begin
    case (lenCode)
      LEN_TWO:   maskSel = COL_W'(1);
      LEN_FOUR:  maskSel = COL_W'(3);
      LEN_EIGHT: maskSel = COL_W'(7);
      default:   maskSel = '1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      baseReg <= '0;
      maskReg <= '0;
      ilvReg  <= 1'b0;
      pairIdx <= '0;
    end else if (strb.load) begin
      baseReg <= startCol;
      maskReg <= maskSel;
      ilvReg  <= typeIlv;
      pairIdx <= '0;
    end else if (strb.step) begin
      pairIdx <= pairIdx + 1'b1;
    end
  end

  assign offs = baseReg & maskReg;

  for (genvar lane = 0; lane < LANES; lane++) begin : g_lane
    logic [COL_W-1:0] beatIdx, walked;
    assign beatIdx = {pairIdx, 1'(lane)};
    assign walked  = ilvReg ? (offs ^ beatIdx) : (offs + beatIdx);
    assign laneCol[lane] = (baseReg & ~maskReg) | (walked & maskReg);
  end

  assign colEven = laneCol[0];
  assign colOdd  = laneCol[1];
endmodule

// File: rtl/burst_col_seq.sv
module burst_col_seq
  import burst_col_pkg::*;
#(
  parameter int COL_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startPulse,
  input  logic             stopPulse,
  input  logic [2:0]       lenCode,
  input  logic             typeIlv,
  input  logic [COL_W-1:0] startCol,
  output logic [COL_W-1:0] colEven,
  output logic [COL_W-1:0] colOdd,
  output logic             pairValid,
  output logic             pairLast,
  output logic             cfgErr
);
  seqStrobe_t strb;

  burst_ctrl #(.COL_W(COL_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .startPulse(startPulse), .stopPulse(stopPulse),
    .lenCode(lenCode), .typeIlv(typeIlv), .startLsb(startCol[0]),
    .strb(strb), .busy(pairValid), .lastPair(pairLast), .cfgErr(cfgErr)
  );

  burst_addr #(.COL_W(COL_W)) u_addr (
    .clk(clk), .rstN(rstN), .strb(strb), .lenCode(lenCode),
    .typeIlv(typeIlv), .startCol(startCol),
    .colEven(colEven), .colOdd(colOdd)
  );
endmodule

// File: rtl/burst_col_seq_chk.sv
module burst_col_seq_chk #(
  parameter int COL_W = 8
) (
  input logic             clk,
  input logic             rstN,
  input logic             startPulse,
  input logic             stopPulse,
  input logic [COL_W-1:0] colEven,
  input logic [COL_W-1:0] colOdd,
  input logic             pairValid,
  input logic             pairLast,
  input logic             cfgErr
);
  a_r2_last_is_valid: assert property (@(posedge clk) disable iff (!rstN)
    pairLast |-> pairValid);

  a_r2_last_ends: assert property (@(posedge clk) disable iff (!rstN)
    pairLast && !startPulse |=> !pairValid);

  a_r7_stop_cuts: assert property (@(posedge clk) disable iff (!rstN)
    stopPulse && !startPulse |=> !pairValid);

  a_r10_err_no_pair: assert property (@(posedge clk) disable iff (!rstN)
    cfgErr |-> !pairValid);

  a_r11_pair_lsb: assert property (@(posedge clk) disable iff (!rstN)
    pairValid |-> colEven[0] != colOdd[0]);
endmodule

bind burst_col_seq burst_col_seq_chk #(.COL_W(COL_W)) u_chk (
  .clk(clk), .rstN(rstN), .startPulse(startPulse), .stopPulse(stopPulse),
  .colEven(colEven), .colOdd(colOdd), .pairValid(pairValid),
  .pairLast(pairLast), .cfgErr(cfgErr)
);

// File: tb/burst_col_seq_test.sv
module burst_col_seq_test;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       startPulse = 1'b0, stopPulse = 1'b0, typeIlv = 1'b0;
  logic [2:0] lenCode = 3'b000;
  logic [7:0] startCol = 8'h00;
  logic [7:0] colEven, colOdd;
  logic       pairValid, pairLast, cfgErr;
  int testsRun = 0, testsFailed = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  burst_col_seq uut (
    .clk(clk), .rstN(rstN), .startPulse(startPulse), .stopPulse(stopPulse),
    .lenCode(lenCode), .typeIlv(typeIlv), .startCol(startCol),
    .colEven(colEven), .colOdd(colOdd), .pairValid(pairValid),
    .pairLast(pairLast), .cfgErr(cfgErr)
  );

  function automatic int blockLen(input logic [2:0] code);
    case (code)
      3'b001: return 2;
      3'b010: return 4;
      3'b011: return 8;
      default: return 256;
    endcase
  endfunction

  function automatic logic [7:0] expCol(input logic [2:0] code, input logic ilv,
                                        input int st, input int beat);
    int n = blockLen(code);
    int base = (st / n) * n;
    int off = st % n;
    if (ilv) return 8'(base + ((off ^ beat) % n));
    return 8'(base + ((off + beat) % n));
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    testsRun++;
    if (act !== exp) begin
      testsFailed++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic checkPair(input string tag, input logic [2:0] code, input logic ilv,
                           input int st, input int p, input logic expLast);
    check({tag, " valid"}, pairValid, 1);
    check({tag, " even"}, colEven, expCol(code, ilv, st, 2*p));
    check({tag, " odd"},  colOdd,  expCol(code, ilv, st, 2*p+1));
    check({tag, " last"}, pairLast, expLast);
  endtask

  // called at a negedge; returns at the next negedge with the pulse cleared
  task automatic issue(input logic [2:0] code, input logic ilv, input logic [7:0] st,
                       input logic withStop);
    lenCode = code; typeIlv = ilv; startCol = st;
    startPulse = 1'b1; stopPulse = withStop;
    @(negedge clk);
    startPulse = 1'b0; stopPulse = 1'b0;
  endtask

  task automatic stopNow();
    stopPulse = 1'b1;
    @(negedge clk);
    stopPulse = 1'b0;
  endtask

  task automatic runBurst(input string tag, input logic [2:0] code, input logic ilv,
                          input int st);
    int pairs = blockLen(code) / 2;
    issue(code, ilv, 8'(st), 1'b0);
    for (int p = 0; p < pairs; p++) begin
      checkPair(tag, code, ilv, st, p, p == pairs - 1);
      @(negedge clk);
    end
    check({tag, " R2 ends"}, pairValid, 0);
  endtask

  task automatic t_reset();
    check("R1 valid", pairValid, 0);
    check("R1 last", pairLast, 0);
    check("R1 err", cfgErr, 0);
  endtask

  task automatic t_orders();
    runBurst("R3 seq8 s5", 3'b011, 1'b0, 5);
    runBurst("R4 ilv8 s5", 3'b011, 1'b1, 5);
    runBurst("R2 seq2 s3", 3'b001, 1'b0, 3);
    runBurst("R2 ilv2 s3", 3'b001, 1'b1, 3);
    runBurst("R5 seq4 s2D", 3'b010, 1'b0, 8'h2D);
    runBurst("R5 ilv4 s2D", 3'b010, 1'b1, 8'h2D);
    runBurst("R3 seq8 sC6", 3'b011, 1'b0, 8'hC6);
  endtask

  task automatic t_page();
    issue(3'b111, 1'b0, 8'hFA, 1'b0);
    for (int p = 0; p < 10; p++) begin
      checkPair("R6 page", 3'b111, 1'b0, 8'hFA, p, 1'b0);
      @(negedge clk);
    end
    checkPair("R6 page", 3'b111, 1'b0, 8'hFA, 10, 1'b0);
    stopNow();
    for (int k = 0; k < 3; k++) begin
      check("R7 page stopped", pairValid, 0);
      @(negedge clk);
    end
  endtask

  task automatic t_stopMid();
    issue(3'b011, 1'b1, 8'h40, 1'b0);
    checkPair("R7 pre", 3'b011, 1'b1, 8'h40, 0, 1'b0);
    stopNow();
    check("R7 cut", pairValid, 0);
    @(negedge clk);
    check("R7 stays cut", pairValid, 0);
    check("R7 last", pairLast, 0);
  endtask

  task automatic t_restart();
    issue(3'b011, 1'b0, 8'h00, 1'b0);
    checkPair("R8 old", 3'b011, 1'b0, 0, 0, 1'b0);
    issue(3'b010, 1'b0, 8'h12, 1'b0);
    checkPair("R8 new p0", 3'b010, 1'b0, 8'h12, 0, 1'b0);
    @(negedge clk);
    checkPair("R8 new p1", 3'b010, 1'b0, 8'h12, 1, 1'b1);
    // new command exactly on the final pair: back-to-back burst
    issue(3'b001, 1'b1, 8'h77, 1'b0);
    checkPair("R8 chained", 3'b001, 1'b1, 8'h77, 0, 1'b1);
    @(negedge clk);
    check("R8 chained ends", pairValid, 0);
  endtask

  task automatic t_both();
    issue(3'b011, 1'b1, 8'h90, 1'b0);
    checkPair("R9 old", 3'b011, 1'b1, 8'h90, 0, 1'b0);
    issue(3'b011, 1'b0, 8'h33, 1'b1);
    checkPair("R9 start wins", 3'b011, 1'b0, 8'h33, 0, 1'b0);
    stopNow();
    check("R9 then stop", pairValid, 0);
  endtask

  task automatic badCmd(input string tag, input logic [2:0] code, input logic ilv,
                        input logic [7:0] st);
    issue(code, ilv, st, 1'b0);
    check({tag, " err"}, cfgErr, 1);
    check({tag, " no pair"}, pairValid, 0);
    @(negedge clk);
    check({tag, " err pulse"}, cfgErr, 0);
    check({tag, " still idle"}, pairValid, 0);
  endtask

  task automatic t_errors();
    badCmd("R10 code000", 3'b000, 1'b0, 8'h10);
    badCmd("R10 code100", 3'b100, 1'b0, 8'h10);
    badCmd("R10 code110", 3'b110, 1'b1, 8'h10);
    badCmd("R10 page ilv", 3'b111, 1'b1, 8'h10);
    badCmd("R10 page odd", 3'b111, 1'b0, 8'h11);
    issue(3'b011, 1'b0, 8'h08, 1'b0);
    checkPair("R10 running", 3'b011, 1'b0, 8'h08, 0, 1'b0);
    badCmd("R10 mid burst", 3'b101, 1'b0, 8'h08);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_orders();
    t_page();
    t_stopMid();
    t_restart();
    t_both();
    t_errors();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      testsRun++;
      testsFailed++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end
endmodule